// File: doc/BRIEF.md
# Fault Event Interrupt Controller

This block turns a small group of fault status flags into a single interrupt message request. One flag reflects the fault-valid bits of an external set of fault recording entries. The other four are sticky flags, set by one-cycle hardware event strobes: advanced-log fault, invalidation queue error, invalidation completion error and invalidation time-out. Software clears the sticky flags by writing ones to them through a simple register write port.

A control register holds an interrupt mask bit and a hardware-owned pending bit. Pending is armed only when the flag group goes from all-clear to non-empty. It is held while the mask is set or a transient stall input is high. It is released by issuing a one-cycle message request that carries the programmed data and address values. If software services every flag first, pending is dropped silently and no message is sent. Message transport and the fault record storage sit outside the block.

Top module: `fault_evt_irq`

## Requirements
- R1: After reset, `ctl_rd_o` reads 0x80000000 (mask set, pending clear), `sts_rd_o` reads 0 and `msg_req_o` is low.
- R2: In the control word, bit 31 is the mask and is written from `wr_data_i[31]` when `wr_en_i` is high and `wr_sel_i` is 0. Bit 30 is pending and ignores writes. Bits 29:0 read as zero.
- R3: `msg_req_o` is never high in a cycle that follows a cycle with the mask set.
- R4: Pending becomes 1 at the clock edge where the status flags go from all clear to at least one set. A flag that sets while another flag is already set does not re-arm pending.
- R5: In a cycle with pending 1, mask 0 and `stall_i` 0, the next edge raises `msg_req_o` for exactly one cycle and clears pending. `msg_data_o`/`msg_addr_o` then hold `evt_data_i`/`evt_addr_i` from that cycle.
- R6: While `stall_i` is high, a pending message is held and pending stays 1, even after the mask is cleared.
- R7: When every status flag becomes clear, pending clears at the same edge and no message is issued.
- R8: Status layout: bit 0 is the registered OR of `rec_fault_i` and is read-only. Bits 1..4 are sticky flags, set by `sticky_set_i[0..3]` in that order. They are cleared by writing 1 to the bit with `wr_en_i` high and `wr_sel_i` 1. Writing 1 to bit 0 has no effect.
- R9: When a sticky flag's set strobe and a clear write to that flag arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_fault_i | input | NUM_REC | Fault-valid bits of the recording entries |
| sticky_set_i | input | 4 | One-cycle set strobes for status bits 1..4 |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 1 | Write target: 0 control, 1 status |
| wr_data_i | input | 32 | Write data |
| stall_i | input | 1 | Transient condition that blocks message issue |
| evt_data_i | input | DATA_W | Programmed message data |
| evt_addr_i | input | ADDR_W | Programmed message address |
| ctl_rd_o | output | 32 | Control word read value |
| sts_rd_o | output | 5 | Status flags read value |
| msg_req_o | output | 1 | One-cycle message request |
| msg_data_o | output | DATA_W | Data carried by the message |
| msg_addr_o | output | ADDR_W | Address carried by the message |

## Verification
The hardest case to reach is an armed pending bit that must be dropped without a message. This needs an event while masked, software clearing every flag, and then unmasking, with no request afterwards. The stimulus table builds this sequence, and also one where a stall is held across the unmask edge and released later. It also places a set strobe and a clear write on the same flag in one cycle, and sets a second flag while another is already set, to show that pending is not re-armed.

// File: rtl/fault_evt_pkg.sv
package fault_evt_pkg;
  localparam int REG_W      = 32;
  localparam int NUM_STICKY = 4;
  localparam int STS_W      = NUM_STICKY + 1;
  localparam int MASK_BIT   = REG_W - 1;
  localparam int PEND_BIT   = REG_W - 2;
  localparam logic SEL_CTL  = 1'b0;
  localparam logic SEL_STS  = 1'b1;
endpackage

// File: rtl/fault_status_flags.sv
module fault_status_flags
  import fault_evt_pkg::*;
#(
  parameter int NUM_REC = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_REC-1:0]    rec_fault_i,
  input  logic [NUM_STICKY-1:0] sticky_set_i,
  input  logic                  clr_en_i,
  input  logic [NUM_STICKY-1:0] clr_bits_i,
  output logic [STS_W-1:0]      flags_o,
  output logic                  any_q_o,
  output logic                  any_d_o
);
  logic                  prim_q;
  logic                  prim_d;
  logic [NUM_STICKY-1:0] stk_q;
  logic [NUM_STICKY-1:0] stk_d;

  assign prim_d = |rec_fault_i;

  // Set strobe dominates a same-cycle clear
  genvar k;
  generate
    for (k = 0; k < NUM_STICKY; k++) begin : g_flag
      assign stk_d[k] = sticky_set_i[k] | (stk_q[k] & ~(clr_en_i & clr_bits_i[k]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prim_q <= 1'b0;
      stk_q  <= '0;
    end else begin
      prim_q <= prim_d;
      stk_q  <= stk_d;
    end
  end

  assign flags_o = {stk_q, prim_q};
  assign any_q_o = |{stk_q, prim_q};
  assign any_d_o = |{stk_d, prim_d};

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|sticky_set_i) |=> ((stk_q & $past(sticky_set_i)) == $past(sticky_set_i)));
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr_i,
  input  logic              mask_wr_i,
  input  logic              any_q_i,
  input  logic              any_d_i,
  input  logic              stall_i,
  input  logic [DATA_W-1:0] evt_data_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  output logic              mask_o,
  output logic              pend_o,
  output logic              msg_req_o,
  output logic [DATA_W-1:0] msg_data_o,
  output logic [ADDR_W-1:0] msg_addr_o
);
  logic              mask_q;
  logic              pend_q;
  logic              req_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_q;
  logic              new_cond;
  logic              issue;

  assign new_cond = any_d_i & ~any_q_i;
  assign issue    = pend_q & ~mask_q & ~stall_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b1;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      data_q <= '0;
      addr_q <= '0;
    end else begin
      if (ctl_wr_i) mask_q <= mask_wr_i;
      if (new_cond)                pend_q <= 1'b1;
      else if (issue || !any_d_i)  pend_q <= 1'b0;
      req_q <= issue;
      if (issue) begin
        data_q <= evt_data_i;
        addr_q <= evt_addr_i;
      end
    end
  end

  assign mask_o     = mask_q;
  assign pend_o     = pend_q;
  assign msg_req_o  = req_q;
  assign msg_data_o = data_q;
  assign msg_addr_o = addr_q;

  // R3
  masked_req_chk: assert property (@(posedge clk) disable iff (rst)
    msg_req_o |-> $past(!mask_q));
  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    msg_req_o |=> !msg_req_o);
  // R4
  arm_chk: assert property (@(posedge clk) disable iff (rst)
    (any_d_i && !any_q_i) |=> pend_q);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && stall_i && any_d_i) |=> (pend_q && !msg_req_o));
  // R7
  pend_flag_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> any_q_i);
endmodule

// File: rtl/fault_evt_irq.sv
module fault_evt_irq
  import fault_evt_pkg::*;
#(
  parameter int NUM_REC = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_REC-1:0]    rec_fault_i,
  input  logic [NUM_STICKY-1:0] sticky_set_i,
  input  logic                  wr_en_i,
  input  logic                  wr_sel_i,
  input  logic [REG_W-1:0]      wr_data_i,
  input  logic                  stall_i,
  input  logic [DATA_W-1:0]     evt_data_i,
  input  logic [ADDR_W-1:0]     evt_addr_i,
  output logic [REG_W-1:0]      ctl_rd_o,
  output logic [STS_W-1:0]      sts_rd_o,
  output logic                  msg_req_o,
  output logic [DATA_W-1:0]     msg_data_o,
  output logic [ADDR_W-1:0]     msg_addr_o
);
  logic any_q;
  logic any_d;
  logic mask;
  logic pend;
  logic ctl_wr;
  logic sts_wr;
  logic unused_wr;

  assign ctl_wr    = wr_en_i & (wr_sel_i == SEL_CTL);
  assign sts_wr    = wr_en_i & (wr_sel_i == SEL_STS);
  assign unused_wr = ^{wr_data_i[PEND_BIT:STS_W], wr_data_i[0]};

  fault_status_flags #(.NUM_REC(NUM_REC)) u_flags (
    .clk          (clk),
    .rst          (rst),
    .rec_fault_i  (rec_fault_i),
    .sticky_set_i (sticky_set_i),
    .clr_en_i     (sts_wr),
    .clr_bits_i   (wr_data_i[STS_W-1:1]),
    .flags_o      (sts_rd_o),
    .any_q_o      (any_q),
    .any_d_o      (any_d)
  );

  irq_pend_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctl_wr_i   (ctl_wr),
    .mask_wr_i  (wr_data_i[MASK_BIT]),
    .any_q_i    (any_q),
    .any_d_i    (any_d),
    .stall_i    (stall_i),
    .evt_data_i (evt_data_i),
    .evt_addr_i (evt_addr_i),
    .mask_o     (mask),
    .pend_o     (pend),
    .msg_req_o  (msg_req_o),
    .msg_data_o (msg_data_o),
    .msg_addr_o (msg_addr_o)
  );

  assign ctl_rd_o = {mask, pend, {(REG_W-2){1'b0}}};
endmodule

// File: tb/fault_evt_irq_test.sv
`timescale 1ns/1ps
module fault_evt_irq_test;
  localparam int NREC = 4;
  localparam logic [31:0] DATA = 32'hC0DE_1234;
  localparam logic [31:0] ADDR = 32'hFEE0_0040;

  typedef struct packed {
    logic [3:0] rec;
    logic [3:0] set;
    logic       wen;
    logic       wsel;
    logic       wmask;
    logic [4:0] wclr;
    logic       stall;
    logic       e_req;
    logic       e_pend;
    logic       e_mask;
    logic [4:0] e_flags;
  } vec_t;

  localparam int NV = 27;
  // rec, set, wen, wsel, wmask, wclr, stall | req, pend, mask, flags
  localparam vec_t TBL [NV] = '{
    '{4'h0,4'h0,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b0,1'b0,1'b1,5'h00}, // idle
    '{4'h0,4'h1,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b0,1'b1,1'b1,5'h02}, // R3 masked event
    '{4'h0,4'h0,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b0,1'b1,1'b1,5'h02},
    '{4'h0,4'h0,1'b1,1'b0,1'b0,5'h00,1'b0, 1'b0,1'b1,1'b0,5'h02}, // unmask
    '{4'h0,4'h0,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b1,1'b0,1'b0,5'h02}, // R5 issue
    '{4'h0,4'h0,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b0,1'b0,1'b0,5'h02},
    '{4'h0,4'h2,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b0,1'b0,1'b0,5'h06}, // R4 no re-arm
    '{4'h0,4'h0,1'b1,1'b1,1'b0,5'h06,1'b0, 1'b0,1'b0,1'b0,5'h00}, // R8 clear
    '{4'h1,4'h0,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b0,1'b1,1'b0,5'h01}, // R8 primary
    '{4'h1,4'h0,1'b0,1'b0,1'b0,5'h00,1'b1, 1'b0,1'b1,1'b0,5'h01}, // R6 stall
    '{4'h1,4'h0,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b1,1'b0,1'b0,5'h01},
    '{4'h0,4'h0,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b0,1'b0,1'b0,5'h00},
    '{4'h0,4'h0,1'b1,1'b0,1'b1,5'h00,1'b0, 1'b0,1'b0,1'b1,5'h00}, // mask
    '{4'h0,4'h8,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b0,1'b1,1'b1,5'h10},
    '{4'h0,4'h0,1'b1,1'b1,1'b0,5'h10,1'b0, 1'b0,1'b0,1'b1,5'h00}, // R7 serviced
    '{4'h0,4'h0,1'b1,1'b0,1'b0,5'h00,1'b0, 1'b0,1'b0,1'b0,5'h00}, // unmask
    '{4'h0,4'h0,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b0,1'b0,1'b0,5'h00}, // R7 no message
    '{4'h0,4'h4,1'b1,1'b1,1'b0,5'h08,1'b0, 1'b0,1'b1,1'b0,5'h08}, // R9 set wins
    '{4'h0,4'h0,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b1,1'b0,1'b0,5'h08},
    '{4'h2,4'h0,1'b1,1'b1,1'b0,5'h09,1'b0, 1'b0,1'b0,1'b0,5'h01}, // R8 bit0 ignores W1C
    '{4'h0,4'h0,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b0,1'b0,1'b0,5'h00},
    '{4'h0,4'h0,1'b1,1'b0,1'b1,5'h00,1'b0, 1'b0,1'b0,1'b1,5'h00}, // mask
    '{4'h0,4'h1,1'b0,1'b0,1'b0,5'h00,1'b1, 1'b0,1'b1,1'b1,5'h02}, // R6
    '{4'h0,4'h0,1'b1,1'b0,1'b0,5'h00,1'b1, 1'b0,1'b1,1'b0,5'h02}, // unmask in stall
    '{4'h0,4'h0,1'b0,1'b0,1'b0,5'h00,1'b1, 1'b0,1'b1,1'b0,5'h02},
    '{4'h0,4'h0,1'b0,1'b0,1'b0,5'h00,1'b0, 1'b1,1'b0,1'b0,5'h02},
    '{4'h0,4'h0,1'b1,1'b1,1'b0,5'h02,1'b0, 1'b0,1'b0,1'b0,5'h00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NREC-1:0] rec_fault = '0;
  logic [3:0]  sticky_set = '0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        stall = 1'b0;
  logic [31:0] ctl_rd;
  logic [4:0]  sts_rd;
  logic        msg_req;
  logic [31:0] msg_data;
  logic [31:0] msg_addr;
  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  fault_evt_irq #(.NUM_REC(NREC), .DATA_W(32), .ADDR_W(32)) uut (
    .clk(clk), .rst(rst), .rec_fault_i(rec_fault), .sticky_set_i(sticky_set),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .stall_i(stall),
    .evt_data_i(DATA), .evt_addr_i(ADDR), .ctl_rd_o(ctl_rd), .sts_rd_o(sts_rd),
    .msg_req_o(msg_req), .msg_data_o(msg_data), .msg_addr_o(msg_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    rec_fault = '0; sticky_set = '0; wr_en = 1'b0; wr_sel = 1'b0;
    wr_data = '0; stall = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    chk("R1 ctl", ctl_rd, 32'h8000_0000);
    chk("R1 sts", {27'b0, sts_rd}, 32'h0);
    chk("R1 req", {31'b0, msg_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      rec_fault  = TBL[i].rec;
      sticky_set = TBL[i].set;
      wr_en      = TBL[i].wen;
      wr_sel     = TBL[i].wsel;
      wr_data    = TBL[i].wsel ? {27'b0, TBL[i].wclr} : {TBL[i].wmask, 31'b0};
      stall      = TBL[i].stall;
      tick();
      chk($sformatf("R5 req row %0d", i), {31'b0, msg_req}, {31'b0, TBL[i].e_req});
      chk($sformatf("R4 pend row %0d", i), {31'b0, ctl_rd[30]}, {31'b0, TBL[i].e_pend});
      chk($sformatf("R2 mask row %0d", i), {31'b0, ctl_rd[31]}, {31'b0, TBL[i].e_mask});
      chk($sformatf("R8 flags row %0d", i), {27'b0, sts_rd}, {27'b0, TBL[i].e_flags});
      if (TBL[i].e_req) begin
        chk($sformatf("R5 data row %0d", i), msg_data, DATA);
        chk($sformatf("R5 addr row %0d", i), msg_addr, ADDR);
      end
    end
    quiet();

    // R2: pending bit and reserved bits ignore writes
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'hFFFF_FFFF;
    tick();
    chk("R2 all-ones write", ctl_rd, 32'h8000_0000);
    wr_data = 32'h4000_0000;
    tick();
    chk("R2 pend write ignored", ctl_rd, 32'h0000_0000);
    quiet();

    // R1: reset in the middle of activity
    sticky_set = 4'h1;
    tick();
    sticky_set = 4'h0;
    chk("R4 armed before reset", ctl_rd, 32'h4000_0000);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 ctl after reset", ctl_rd, 32'h8000_0000);
    chk("R1 sts after reset", {27'b0, sts_rd}, 32'h0);
    tick();
    chk("R1 no req after reset", {31'b0, msg_req}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule